// File: doc/BRIEF.md
# Bit-Serial Distributed-Arithmetic FIR Filter

This block is a four-tap FIR filter with fixed coefficients. It has no multipliers and computes one output per accepted input sample, working bit-serially. A parallel two's-complement sample is handed over with a valid strobe while the block reports ready. The sample enters a four-deep delay line, with the newest sample at tap 0.

Over the following cycles the block takes one bit position at a time, from the least significant bit up, across all four stored samples. The two bits from taps 0 and 1 address one four-word table of coefficient subset sums. The two bits from taps 2 and 3 address a second such table. The two table words are added, weighted by the bit position, and folded into an accumulator. On the sign-bit cycle the sum is subtracted instead of added.

When all bit cycles are done, the full-precision result is registered and a one-cycle done strobe is raised. A build parameter chooses the accumulator: a plain adder that carries through each cycle, or a carry-save pair of vectors that is resolved by a single add when the result is captured.

Top module: `dafir_filter`

## Requirements
- R1: A synchronous active-high reset clears the delay line, the accumulator and the control state. After reset `in_ready` is 1, `out_valid` is 0 and `out_result` is 0. The first result after reset treats taps 1 to 3 as zero.
- R2: A sample is taken only when `in_valid` is high in a cycle where `in_ready` is high. `in_ready` is low from the cycle after acceptance until the result has been delivered. `in_valid` pulses in that interval do not change the delay line or any later result.
- R3: If a sample is accepted at clock edge E, `out_valid` is high for exactly one cycle, following edge E + DATA_W + 1. `in_ready` is high again from that same edge.
- R4: `out_result` equals C0·x[n] + C1·x[n−1] + C2·x[n−2] + C3·x[n−3] exactly. Samples and result are signed two's complement, and the result is OUT_W = DATA_W + COEF_W + 2 bits wide with no rounding.
- R5: Each accepted sample moves the delay line by one place. The new sample goes to tap 0 and the oldest sample is dropped.
- R6: Full-scale inputs, including the most negative sample value, produce the exact product sum without wrap-around.
- R7: The carry-save accumulator variant (CARRY_SAVE = 1) gives the same results and the same timing as the ripple variant.
- R8: `out_result` keeps its value in every cycle where `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | DATA_W | Signed input sample |
| in_ready | output | 1 | High while the block can accept a sample |
| out_valid | output | 1 | One-cycle strobe marking a fresh result |
| out_result | output | OUT_W | Signed full-precision filter output |

## Verification
The bench builds two copies side by side with the default widths (8-bit samples and 8-bit coefficients) and the same coefficients 13, −7, 100 and −128. One copy uses the ripple accumulator and the other the carry-save accumulator. Every output of the two copies is checked against a single reference model, which makes the equivalence and timing claims of R7 directly observable. The −128 coefficient, together with −128 samples, drives the sign-bit subtraction and the full output range.

// File: rtl/dafir_pkg.sv
package dafir_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } dafir_state_e;

    // Sum of the coefficients selected by a two-bit table address.
    function automatic int pair_sum(input int addr, input int c_lo, input int c_hi);
        int s;
        s = 0;
        if ((addr % 2) != 0) s = s + c_lo;
        if ((addr / 2) != 0) s = s + c_hi;
        return s;
    endfunction

endpackage

// File: rtl/dafir_tap_line.sv
module dafir_tap_line #(
    parameter int DATA_W = 8,
    parameter int TAPS   = 4,
    localparam int SH_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en,
    input  logic [DATA_W-1:0] din,
    input  logic [SH_W-1:0]   bit_sel,
    output logic [TAPS-1:0]   bits_o
);

    logic [TAPS-1:0][DATA_W-1:0] tap_d, tap_q;

    always_comb begin
        tap_d = tap_q;
        if (shift_en) begin
            tap_d[0] = din;
            for (int i = 1; i < TAPS; i++) begin
                tap_d[i] = tap_q[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) tap_q <= '0;
        else     tap_q <= tap_d;
    end

    for (genvar g = 0; g < TAPS; g++) begin : g_bit
        assign bits_o[g] = tap_q[g][bit_sel];
    end

    AST_TAPS_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(tap_q)) else $error("taps moved without shift"); // R2

endmodule

// File: rtl/dafir_half_lut.sv
module dafir_half_lut #(
    parameter int COEF_W = 8,
    parameter int C_LO   = 0,
    parameter int C_HI   = 0,
    localparam int HW    = COEF_W + 1
) (
    input  logic [1:0]           addr,
    output logic signed [HW-1:0] word_o
);
    import dafir_pkg::*;

    logic signed [HW-1:0] tbl [4];

    for (genvar g = 0; g < 4; g++) begin : g_entry
        localparam int V = pair_sum(g, C_LO, C_HI);
        assign tbl[g] = HW'(V);
    end

    assign word_o = tbl[addr];

endmodule

// File: rtl/dafir_shift_acc.sv
module dafir_shift_acc #(
    parameter int P_W        = 10,
    parameter int OUT_W      = 18,
    parameter int SH_W       = 3,
    parameter bit CARRY_SAVE = 1'b0
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr,
    input  logic                    en,
    input  logic                    neg,
    input  logic [SH_W-1:0]         shamt,
    input  logic signed [P_W-1:0]   partial,
    output logic signed [OUT_W-1:0] result
);

    logic signed [OUT_W-1:0] ext;
    logic signed [OUT_W-1:0] addend;

    always_comb begin
        ext    = {{(OUT_W-P_W){partial[P_W-1]}}, partial};
        addend = (neg ? -ext : ext) <<< shamt;
    end

    if (CARRY_SAVE) begin : g_csa
        typedef struct packed {
            logic [OUT_W-1:0] sum;
            logic [OUT_W-1:0] cry;
        } csa_t;

        csa_t st_d, st_q;

        always_comb begin
            st_d = st_q;
            if (clr) begin
                st_d = '0;
            end else if (en) begin
                st_d.sum = st_q.sum ^ st_q.cry ^ addend;
                st_d.cry = ((st_q.sum & st_q.cry) |
                            (st_q.sum & addend)   |
                            (st_q.cry & addend)) << 1;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) st_q <= '0;
            else     st_q <= st_d;
        end

        assign result = st_q.sum + st_q.cry;
    end else begin : g_ripple
        logic signed [OUT_W-1:0] acc_d, acc_q;

        always_comb begin
            acc_d = acc_q;
            if (clr)     acc_d = '0;
            else if (en) acc_d = acc_q + addend;
        end

        always_ff @(posedge clk) begin
            if (rst) acc_q <= '0;
            else     acc_q <= acc_d;
        end

        assign result = acc_q;
    end

    AST_ACC_CLEARED: assert property (@(posedge clk) disable iff (rst)
        clr |=> (result == '0)) else $error("accumulator not cleared"); // R1

endmodule

// File: rtl/dafir_filter.sv
module dafir_filter #(
    parameter int DATA_W     = 8,
    parameter int COEF_W     = 8,
    parameter int C0         = 13,
    parameter int C1         = -7,
    parameter int C2         = 100,
    parameter int C3         = -128,
    parameter bit CARRY_SAVE = 1'b0,
    localparam int OUT_W     = DATA_W + COEF_W + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_sample,
    output logic              in_ready,
    output logic              out_valid,
    output logic [OUT_W-1:0]  out_result
);
    import dafir_pkg::*;

    localparam int TAPS = 4;
    localparam int SH_W = $clog2(DATA_W);
    localparam int HW   = COEF_W + 1;
    localparam int P_W  = COEF_W + 2;
    localparam logic [SH_W-1:0] LAST_BIT = SH_W'(DATA_W - 1);

    typedef struct packed {
        dafir_state_e     state;
        logic [SH_W-1:0]  bit_cnt;
        logic [OUT_W-1:0] result;
        logic             done;
    } ctrl_t;

    ctrl_t c_d, c_q;

    logic                    accept;
    logic [TAPS-1:0]         tap_bits;
    logic signed [HW-1:0]    word_lo, word_hi;
    logic signed [P_W-1:0]   partial;
    logic signed [OUT_W-1:0] acc_res;

    assign in_ready = (c_q.state == ST_IDLE);
    assign accept   = in_valid && in_ready;

    dafir_tap_line #(
        .DATA_W (DATA_W),
        .TAPS   (TAPS)
    ) u_taps (
        .clk      (clk),
        .rst      (rst),
        .shift_en (accept),
        .din      (in_sample),
        .bit_sel  (c_q.bit_cnt),
        .bits_o   (tap_bits)
    );

    dafir_half_lut #(
        .COEF_W (COEF_W),
        .C_LO   (C0),
        .C_HI   (C1)
    ) u_lut_lo (
        .addr   (tap_bits[1:0]),
        .word_o (word_lo)
    );

    dafir_half_lut #(
        .COEF_W (COEF_W),
        .C_LO   (C2),
        .C_HI   (C3)
    ) u_lut_hi (
        .addr   (tap_bits[3:2]),
        .word_o (word_hi)
    );

    assign partial = P_W'(word_lo) + P_W'(word_hi);

    dafir_shift_acc #(
        .P_W        (P_W),
        .OUT_W      (OUT_W),
        .SH_W       (SH_W),
        .CARRY_SAVE (CARRY_SAVE)
    ) u_acc (
        .clk     (clk),
        .rst     (rst),
        .clr     (accept),
        .en      (c_q.state == ST_RUN),
        .neg     (c_q.bit_cnt == LAST_BIT),
        .shamt   (c_q.bit_cnt),
        .partial (partial),
        .result  (acc_res)
    );

    always_comb begin
        c_d      = c_q;
        c_d.done = 1'b0;
        case (c_q.state)
            ST_IDLE: begin
                if (accept) begin
                    c_d.state   = ST_RUN;
                    c_d.bit_cnt = '0;
                end
            end
            ST_RUN: begin
                if (c_q.bit_cnt == LAST_BIT) begin
                    c_d.state = ST_FIN;
                end else begin
                    c_d.bit_cnt = c_q.bit_cnt + 1'b1;
                end
            end
            ST_FIN: begin
                c_d.result  = acc_res;
                c_d.done    = 1'b1;
                c_d.state   = ST_IDLE;
                c_d.bit_cnt = '0;
            end
            default: c_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            c_q.state   <= ST_IDLE;
            c_q.bit_cnt <= '0;
            c_q.result  <= '0;
            c_q.done    <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    assign out_valid  = c_q.done;
    assign out_result = c_q.result;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid) else $error("done longer than a cycle"); // R3
    AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_result)) else $error("result moved"); // R8
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        accept |=> !in_ready) else $error("ready after accept"); // R2
    AST_BIT_RANGE: assert property (@(posedge clk) disable iff (rst)
        c_q.bit_cnt <= LAST_BIT) else $error("bit counter out of range"); // R3

endmodule

// File: tb/dafir_filter_tb.sv
module dafir_filter_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;
    localparam int CW = 8;
    localparam int OW = DW + CW + 2;
    localparam int K0 = 13;
    localparam int K1 = -7;
    localparam int K2 = 100;
    localparam int K3 = -128;

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid;
    logic [DW-1:0] in_sample;
    logic          rdy_a, rdy_b, vld_a, vld_b;
    logic [OW-1:0] res_a, res_b;

    int n_tests = 0;
    int n_fail  = 0;
    int hist [4];
    int last_exp = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dafir_filter #(.DATA_W(DW), .COEF_W(CW), .C0(K0), .C1(K1), .C2(K2), .C3(K3),
                   .CARRY_SAVE(1'b0)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
        .in_ready(rdy_a), .out_valid(vld_a), .out_result(res_a));

    dafir_filter #(.DATA_W(DW), .COEF_W(CW), .C0(K0), .C1(K1), .C2(K2), .C3(K3),
                   .CARRY_SAVE(1'b1)) u_dut_csa (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
        .in_ready(rdy_b), .out_valid(vld_b), .out_result(res_b));

    task automatic chk(input string what, input longint act, input longint exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    function automatic int model_out();
        return K0*hist[0] + K1*hist[1] + K2*hist[2] + K3*hist[3];
    endfunction

    // Accept one sample, optionally poke in_valid during the busy interval.
    task automatic send(input int x, input bit poke, input int junk);
        int e;
        @(negedge clk);
        chk("R2 ready before send (ripple)", rdy_a, 1);
        in_valid  = 1'b1;
        in_sample = DW'(x);
        @(negedge clk);
        in_valid  = poke;
        in_sample = DW'(junk);
        chk("R2 ready low after accept (ripple)", rdy_a, 0);
        chk("R7 ready low after accept (csa)", rdy_b, 0);
        for (int i = 3; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = x;
        e = model_out();
        for (int i = 1; i <= DW + 1; i++) begin
            @(negedge clk);
            if (i <= DW) begin
                chk("R3 done low while busy", vld_a, 0);
                if (i == 4) begin
                    chk("R8 result held (ripple)", $signed(res_a), last_exp);
                    chk("R8 result held (csa)", $signed(res_b), last_exp);
                end
            end else begin
                chk("R3 done at DATA_W+1 (ripple)", vld_a, 1);
                chk("R7 done at DATA_W+1 (csa)", vld_b, 1);
            end
        end
        in_valid = 1'b0;
        chk("R4 result (ripple)", $signed(res_a), e);
        chk("R7 result (csa)", $signed(res_b), e);
        chk("R3 ready back", rdy_a, 1);
        last_exp = e;
        @(negedge clk);
        chk("R3 done single cycle", vld_a, 0);
        chk("R8 result kept after done", $signed(res_a), e);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        in_valid = 1'b0;
        in_sample = '0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 4; i++) hist[i] = 0;
        last_exp = 0;
    endtask

    task automatic t_reset_state();
        do_reset();
        chk("R1 ready after reset", rdy_a, 1);
        chk("R1 done low after reset", vld_a, 0);
        chk("R1 result zero after reset", $signed(res_a), 0);
        chk("R1 result zero after reset (csa)", $signed(res_b), 0);
        send(57, 1'b0, 0);
        chk("R1 first result is C0*x", last_exp, K0*57);
    endtask

    task automatic t_reset_midrun();
        send(-90, 1'b0, 0);
        @(negedge clk);
        in_valid = 1'b1;
        in_sample = DW'(33);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        do_reset();
        chk("R1 ready after mid-run reset", rdy_a, 1);
        chk("R1 result cleared mid-run", $signed(res_a), 0);
        send(-5, 1'b0, 0);
        chk("R1 taps cleared by reset", last_exp, K0*(-5));
    endtask

    task automatic t_stream();
        send(1, 1'b0, 0);
        send(2, 1'b0, 0);
        send(3, 1'b0, 0);
        send(4, 1'b0, 0);
        chk("R5 ordering newest at tap 0", last_exp, K0*4 + K1*3 + K2*2 + K3*1);
        send(-17, 1'b0, 0);
        send(99, 1'b0, 0);
        send(0, 1'b0, 0);
        send(-1, 1'b0, 0);
    endtask

    task automatic t_busy_ignore();
        send(10, 1'b1, 77);
        send(20, 1'b1, -66);
        chk("R2 busy pulses not in delay line", last_exp, K0*20 + K1*10 + K2*hist[2] + K3*hist[3]);
    endtask

    task automatic t_extremes();
        send(-128, 1'b0, 0);
        send(-128, 1'b0, 0);
        send(-128, 1'b0, 0);
        send(-128, 1'b0, 0);
        chk("R6 all most-negative", last_exp, -128 * (K0 + K1 + K2 + K3));
        send(127, 1'b0, 0);
        send(-128, 1'b0, 0);
        send(127, 1'b0, 0);
        send(127, 1'b0, 0);
        send(-128, 1'b0, 0);
        send(127, 1'b0, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        n_tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1;
        in_valid = 1'b0;
        in_sample = '0;
        t_reset_state();
        t_stream();
        t_busy_ignore();
        t_extremes();
        t_reset_midrun();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule